// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Aligner

This block sits between a 32-bit instruction memory port and the decoder. Each cycle it may take one aligned 32-bit fetch word and hands the decoder one instruction at a time, with its length, its address and an illegal flag. Compact 16-bit instructions and full 32-bit instructions may come in any order. A 32-bit instruction only needs 16-bit alignment, so it may begin in the upper half of one fetch word and finish in the lower half of the next. A one-halfword holding register keeps whatever part of a fetch word has not yet been used and joins it with the next word when needed. Halfwords are little-endian: the lower-addressed halfword carries the low bits of an instruction.

The length of an instruction is read from its first halfword. If bits [1:0] are not `11`, it is 16 bits long. If bits [1:0] are `11` and bits [4:2] are not `111`, it is 32 bits long. If bits [4:0] are all ones, it is an encoding for a longer instruction. Longer instructions are not supported: such a halfword is passed on alone as an illegal 16-bit parcel. An all-zero instruction is also flagged as illegal. A redirect loads a new target address and empties the holding register. If bit 1 of the target is set, the lower half of the first word fetched after the redirect is dropped.

The control is a three-state machine. `ST_EMPTY` means nothing is held, and the next instruction starts at the lower half of the current fetch word. `ST_HELD` means one halfword is held, and the next instruction starts with it. `ST_SKIP` means a redirect to an odd halfword is pending. The transitions are these:
- EMPTY to EMPTY when a word-aligned 32-bit instruction is emitted.
- EMPTY to HELD when a 16-bit or illegal-long parcel is emitted from the lower half. The upper half is then kept.
- HELD to EMPTY when a held 16-bit or long parcel is emitted.
- HELD to HELD when a straddling 32-bit instruction is emitted. The new upper half is then kept.
- SKIP to HELD when a fetch word is taken. Its upper half is kept and no output is made.
- Any state to EMPTY, or to SKIP, on a redirect, chosen by target bit 1.

Top module: `fetch_aligner`

## Requirements
- R1: After reset the state is EMPTY, `out_pc` equals `RESET_PC` (default 0), and with no fetch word offered `out_valid` and `fetch_ready` are 0.
- R2: A first halfword whose bits [1:0] are not `11` gives a 16-bit instruction: `out_len32`=0 and `out_instr[31:16]`=0. A first halfword with bits [1:0]=`11` and bits [4:2] not `111` gives a 32-bit instruction: `out_len32`=1.
- R3: The instructions of a word come out in order: lower half first, then upper half. A 16-bit instruction appears in `out_instr[15:0]`.
- R4: A 32-bit instruction that starts in an upper half comes out as {lower half of the next word, held upper half}, with `out_pc` bit 1 set.
- R5: A 16-bit instruction whose 16 bits are all zero is emitted with `out_illegal`=1.
- R6: A first halfword whose bits [4:0] are all ones is emitted alone as a 16-bit parcel (`out_len32`=0) with `out_illegal`=1, and the PC advances by 2.
- R7: Every accepted instruction advances `out_pc` by 4 if `out_len32` is 1 and by 2 otherwise. `out_pc` bit 0 is always 0.
- R8: While `out_valid`=1 and `out_ready`=0, `fetch_ready` is 0, and the offered instruction and its PC do not change.
- R9: In the cycle `redirect_valid`=1, `out_valid` and `fetch_ready` are 0. From the next cycle, `out_pc` is the target with bit 0 cleared, and any held halfword is discarded.
- R10: After a redirect with target bit 1 set, the first fetch word is taken without producing an output. Its lower half is dropped, and the first instruction starts at its upper half.
- R11: A held 16-bit parcel is emitted without a fetch word. `fetch_ready` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch word offered |
| fetch_word | input | 32 | Aligned fetch word, lower halfword at the lower address |
| fetch_ready | output | 1 | Fetch word taken this cycle |
| redirect_valid | input | 1 | Load a new target and flush |
| redirect_pc | input | PC_W | Redirect target address |
| out_valid | output | 1 | Instruction offered to the decoder |
| out_ready | input | 1 | Decoder accepts the instruction |
| out_instr | output | 32 | Instruction bits, zero-extended when 16-bit |
| out_len32 | output | 1 | 1 = 32-bit instruction, 0 = 16-bit parcel |
| out_illegal | output | 1 | All-zero or unsupported long encoding |
| out_pc | output | PC_W | Address of the offered instruction |

## Verification
The instruction outputs and `fetch_ready` are combinational from the held state and the word on the input, so they are due in the same cycle as the stimulus. The holding register, the state and the PC change at the next edge after a handshake or a redirect. The bench changes inputs just after each rising edge and samples at the following falling edge, so each accepted instruction is compared in the cycle it is offered. It also checks that a stalled offer is unchanged one edge later. Expected instructions, lengths, flags and addresses come from a separate parse of a halfword image that the bench builds from every four-instruction sequence of the four kinds, at even and odd start addresses, with stall and fetch-gap patterns mixed in.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
    localparam int WORD_W   = 32;
    localparam int PARCEL_W = WORD_W / 2;

    typedef enum logic [1:0] {
        PK_SHORT = 2'd0,
        PK_FULL  = 2'd1,
        PK_LONG  = 2'd2
    } parcel_kind_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HELD  = 2'd1,
        ST_SKIP  = 2'd2
    } align_state_t;
endpackage

// File: rtl/fa_parcel_class.sv
`timescale 1ns/1ps
module fa_parcel_class
    import fa_pkg::*;
(
    input  logic [PARCEL_W-1:0] parcel,
    output parcel_kind_t        kind,
    output logic                is_zero
);
    always_comb begin
        if (parcel[1:0] != 2'b11)
            kind = PK_SHORT;
        else if (parcel[4:2] != 3'b111)
            kind = PK_FULL;
        else
            kind = PK_LONG;
        is_zero = (parcel == '0);
    end
endmodule

// File: rtl/fa_pc_reg.sv
`timescale 1ns/1ps
module fa_pc_reg #(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] load_pc,
    input  logic            step,
    input  logic            step4,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] EVEN_MASK = ~PC_W'(1);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_PC & EVEN_MASK;
        else if (load)
            pc_q <= load_pc & EVEN_MASK;
        else if (step)
            pc_q <= pc_q + (step4 ? PC_W'(4) : PC_W'(2));
    end

    assign pc = pc_q;

    // R7: instruction addresses stay halfword aligned
    p_pc_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[0] == 1'b0);
endmodule

// File: rtl/fetch_aligner.sv
`timescale 1ns/1ps
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_word,
    output logic              fetch_ready,
    input  logic              redirect_valid,
    input  logic [PC_W-1:0]   redirect_pc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_instr,
    output logic              out_len32,
    output logic              out_illegal,
    output logic [PC_W-1:0]   out_pc
);
    localparam int N_CAND = 2;
    localparam int C_HOLD = 0;
    localparam int C_LOW  = 1;

    align_state_t          state_q, state_d;
    logic [PARCEL_W-1:0]   hold_q, hold_d;
    logic [PARCEL_W-1:0]   word_lo, word_hi;
    logic [PARCEL_W-1:0]   cand    [N_CAND];
    parcel_kind_t          kind    [N_CAND];
    logic                  is_zero [N_CAND];
    logic                  emitted;
    logic                  took_word;

    assign word_lo      = fetch_word[PARCEL_W-1:0];
    assign word_hi      = fetch_word[WORD_W-1:PARCEL_W];
    assign cand[C_HOLD] = hold_q;
    assign cand[C_LOW]  = word_lo;

    for (genvar g = 0; g < N_CAND; g++) begin : g_cls
        fa_parcel_class u_cls (
            .parcel  (cand[g]),
            .kind    (kind[g]),
            .is_zero (is_zero[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    // outputs
    always_comb begin
        out_valid   = 1'b0;
        out_instr   = '0;
        out_len32   = 1'b0;
        out_illegal = 1'b0;
        fetch_ready = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (fetch_valid) begin
                    out_valid   = 1'b1;
                    fetch_ready = out_ready;
                    unique case (kind[C_LOW])
                        PK_SHORT: begin
                            out_instr   = {{PARCEL_W{1'b0}}, word_lo};
                            out_illegal = is_zero[C_LOW];
                        end
                        PK_FULL: begin
                            out_instr = fetch_word;
                            out_len32 = 1'b1;
                        end
                        default: begin
                            out_instr   = {{PARCEL_W{1'b0}}, word_lo};
                            out_illegal = 1'b1;
                        end
                    endcase
                end
            end
            ST_HELD: begin
                unique case (kind[C_HOLD])
                    PK_SHORT: begin
                        out_valid   = 1'b1;
                        out_instr   = {{PARCEL_W{1'b0}}, hold_q};
                        out_illegal = is_zero[C_HOLD];
                    end
                    PK_FULL: begin
                        out_valid   = fetch_valid;
                        out_instr   = {word_lo, hold_q};
                        out_len32   = 1'b1;
                        fetch_ready = out_ready;
                    end
                    default: begin
                        out_valid   = 1'b1;
                        out_instr   = {{PARCEL_W{1'b0}}, hold_q};
                        out_illegal = 1'b1;
                    end
                endcase
            end
            ST_SKIP: begin
                fetch_ready = 1'b1;
            end
            default: begin
                fetch_ready = 1'b0;
            end
        endcase
        if (redirect_valid) begin
            out_valid   = 1'b0;
            fetch_ready = 1'b0;
        end
    end

    assign emitted   = out_valid && out_ready;
    assign took_word = fetch_valid && fetch_ready;

    // next state
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        if (redirect_valid) begin
            state_d = redirect_pc[1] ? ST_SKIP : ST_EMPTY;
            hold_d  = '0;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (emitted && kind[C_LOW] != PK_FULL) begin
                        state_d = ST_HELD;
                        hold_d  = word_hi;
                    end
                end
                ST_HELD: begin
                    if (emitted) begin
                        if (kind[C_HOLD] == PK_FULL) begin
                            state_d = ST_HELD;
                            hold_d  = word_hi;
                        end else begin
                            state_d = ST_EMPTY;
                        end
                    end
                end
                ST_SKIP: begin
                    if (took_word) begin
                        state_d = ST_HELD;
                        hold_d  = word_hi;
                    end
                end
                default: begin
                    state_d = ST_EMPTY;
                end
            endcase
        end
    end

    fa_pc_reg #(
        .PC_W     (PC_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (redirect_valid),
        .load_pc (redirect_pc),
        .step    (emitted),
        .step4   (out_len32),
        .pc      (out_pc)
    );

    // R2: a short parcel never carries upper bits
    p_short_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_len32) |-> (out_instr[WORD_W-1:PARCEL_W] == '0));

    // R5: all-zero instruction flagged
    p_zero_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_instr[PARCEL_W-1:0] == '0) |-> out_illegal);

    // R6: long-encoding prefix emitted alone and flagged
    p_long_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_instr[4:0] == 5'h1F) |-> (out_illegal && !out_len32));

    // R7: PC advances by the accepted length
    p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=>
            (out_pc == $past(out_pc) + ($past(out_len32) ? PC_W'(4) : PC_W'(2))));

    // R8: a stalled offer consumes no fetch word
    p_stall_noconsume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !fetch_ready);

    // R8: a stalled offer keeps its address
    p_stall_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !redirect_valid) |=> $stable(out_pc));

    // R9: redirect cycle is quiet on both sides
    p_redirect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!out_valid && !fetch_ready));

    // R9: redirect target becomes the next address
    p_redirect_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (out_pc == ($past(redirect_pc) & ~PC_W'(1))));
endmodule

// File: tb/fetch_aligner_test.sv
`timescale 1ns/1ps
module fetch_aligner_test;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            fetch_valid;
    logic [31:0]     fetch_word;
    logic            fetch_ready;
    logic            redirect_valid;
    logic [PC_W-1:0] redirect_pc;
    logic            out_valid;
    logic            out_ready;
    logic [31:0]     out_instr;
    logic            out_len32;
    logic            out_illegal;
    logic [PC_W-1:0] out_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] mem     [16];
    logic [31:0] e_instr [4];
    logic        e_l32   [4];
    logic        e_ill   [4];
    logic [31:0] e_pc    [4];

    always #10 clk = ~clk;

    fetch_aligner #(.PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word), .fetch_ready(fetch_ready),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
        .out_len32(out_len32), .out_illegal(out_illegal), .out_pc(out_pc)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // builds a halfword image of four instructions and parses the expectation
    task automatic build(input int code, input int odd, input logic [31:0] base);
        int h;
        int a;
        logic [15:0] p;
        for (int i = 0; i < 16; i++) mem[i] = 16'h0001;
        h = odd;
        if (odd != 0) mem[0] = 16'hFFFF;
        for (int k = 0; k < 4; k++) begin
            case ((code >> (2 * k)) & 3)
                0: begin
                    mem[h] = 16'hA000 | 16'(k << 4) | 16'((code + k) % 3);
                    h += 1;
                end
                1: begin
                    mem[h]     = 16'h5003 | 16'(k << 8) | 16'(((code + k) % 7) << 2);
                    mem[h + 1] = 16'hC000 | 16'(code * 4 + k);
                    h += 2;
                end
                2: begin
                    mem[h] = 16'h0000;
                    h += 1;
                end
                default: begin
                    mem[h] = 16'h001F | 16'(k << 8);
                    h += 1;
                end
            endcase
        end
        a = odd;
        for (int k = 0; k < 4; k++) begin
            p       = mem[a];
            e_pc[k] = base + 32'(2 * a);
            if (p[1:0] != 2'b11) begin
                e_instr[k] = {16'h0, p}; e_l32[k] = 1'b0; e_ill[k] = (p == 16'h0); a += 1;
            end else if (p[4:2] != 3'b111) begin
                e_instr[k] = {mem[a + 1], p}; e_l32[k] = 1'b1; e_ill[k] = 1'b0; a += 2;
            end else begin
                e_instr[k] = {16'h0, p}; e_l32[k] = 1'b0; e_ill[k] = 1'b1; a += 1;
            end
        end
    endtask

    task automatic run(input int code, input int odd, input logic [31:0] base);
        int n;
        int fa;
        int cyc;
        bit stall_prev;
        logic [31:0] s_instr;
        logic [31:0] s_pc;
        build(code, odd, base);
        @(posedge clk); #1;
        redirect_valid = 1'b1;
        redirect_pc    = base + 32'(2 * odd);
        fetch_valid    = 1'b0;
        out_ready      = 1'b1;
        @(negedge clk);
        check(!out_valid,   "R9 out_valid during redirect", 32'(out_valid), 32'h0);
        check(!fetch_ready, "R9 fetch_ready during redirect", 32'(fetch_ready), 32'h0);
        @(posedge clk); #1;
        redirect_valid = 1'b0;
        n = 0; fa = 0; cyc = 0; stall_prev = 1'b0; s_instr = '0; s_pc = '0;
        while (n < 4 && cyc < 60) begin
            fetch_valid = (fa < 8) && !(((code & 1) != 0) && (cyc % 4 == 2));
            fetch_word  = (fa < 8) ? {mem[2 * fa + 1], mem[2 * fa]} : 32'h0;
            out_ready   = !(((code & 2) != 0 || odd != 0) && (cyc % 3 == 1));
            @(negedge clk);
            if (stall_prev && out_valid) begin
                check(out_instr == s_instr, "R8 stalled instr", out_instr, s_instr);
                check(out_pc == s_pc, "R8 stalled pc", out_pc, s_pc);
            end
            stall_prev = 1'b0;
            if (out_valid && !out_ready) begin
                check(!fetch_ready, "R8 no consume on stall", 32'(fetch_ready), 32'h0);
                s_instr = out_instr; s_pc = out_pc; stall_prev = 1'b1;
            end
            if (out_valid && out_ready) begin
                check(out_instr == e_instr[n],
                      (e_l32[n] && e_pc[n][1]) ? "R4 straddle instr" : "R3 instr",
                      out_instr, e_instr[n]);
                check(out_len32 == e_l32[n], "R2 length", 32'(out_len32), 32'(e_l32[n]));
                check(out_illegal == e_ill[n],
                      (e_instr[n][4:0] == 5'h1F) ? "R6 long illegal" : "R5 illegal flag",
                      32'(out_illegal), 32'(e_ill[n]));
                check(out_pc == e_pc[n],
                      (n == 0) ? ((odd != 0) ? "R10 first pc after odd redirect" : "R9 first pc")
                               : "R7 pc step",
                      out_pc, e_pc[n]);
                n++;
            end
            if (fetch_valid && fetch_ready) fa++;
            cyc++;
            @(posedge clk); #1;
        end
        check(n == 4, "R7 all instructions delivered", 32'(n), 32'd4);
        fetch_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_word = '0;
        redirect_valid = 1'b0; redirect_pc = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid,   "R1 reset out_valid", 32'(out_valid), 32'h0);
        check(!fetch_ready, "R1 reset fetch_ready", 32'(fetch_ready), 32'h0);
        check(out_pc == 32'h0, "R1 reset pc", out_pc, 32'h0);

        // directed: two short parcels in one word, second one needs no fetch
        @(posedge clk); #1;
        redirect_valid = 1'b1; redirect_pc = 32'h40;
        @(posedge clk); #1;
        redirect_valid = 1'b0;
        fetch_valid = 1'b1; fetch_word = {16'h0005, 16'h0009}; out_ready = 1'b1;
        @(negedge clk);
        check(out_valid && out_instr == 32'h9, "R3 lower half first", out_instr, 32'h9);
        check(fetch_ready, "R3 word taken", 32'(fetch_ready), 32'h1);
        check(out_pc == 32'h40, "R9 pc after redirect", out_pc, 32'h40);
        @(posedge clk); #1;
        fetch_valid = 1'b0;
        @(negedge clk);
        check(out_valid && out_instr == 32'h5, "R11 held parcel emitted", out_instr, 32'h5);
        check(!fetch_ready, "R11 no fetch needed", 32'(fetch_ready), 32'h0);
        check(out_pc == 32'h42, "R7 pc plus two", out_pc, 32'h42);

        for (int odd = 0; odd < 2; odd++) begin
            for (int code = 0; code < 256; code++) begin
                run(code, odd, 32'h1000 + 32'((odd * 256 + code) * 64));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule